// File: doc/BRIEF.md
# Packed Color Lookup Palette

This block is the color lookup memory of a raster display controller. It holds 256 color entries in 128 words of 32 bits, so each word carries two 16-bit entries. A host reaches the words through a byte-addressed register window. A write stores the raw word, with per-byte enables. A read returns the raw word exactly as stored, including the bits that the color path never uses.

On the display side, an 8-bit pixel index selects one entry. The block returns a 24-bit RGB color one clock later. Each 5-bit component is widened to 8 bits by appending three zero bits. The top bit of each entry is an intensity flag, and it plays no part in the color.

Top module: `clut_palette`

## Requirements
- R1: After reset every stored word is zero, and both `bus_rdata` and `lut_rgb` read zero.
- R2: A write with `bus_sel`=1 and `bus_wr`=1 to a byte address in the window 0x200..0x3FF stores into word index (address − 0x200) >> 2. Bits 1:0 of the address are ignored.
- R3: Byte enable bit k gates data bits 8k+7:8k. Lanes whose enable is 0 keep their old contents.
- R4: A write to an address below 0x200 or at/above 0x400 changes no stored word.
- R5: A read (`bus_sel`=1, `bus_wr`=0) in the window drives the raw 32-bit stored word on `bus_rdata` one cycle later, including bits 15 and 31. `bus_rdata` holds its value until the next read.
- R6: A read outside the window drives zero on `bus_rdata` one cycle later.
- R7: Lookup index i selects word i >> 1. An even index uses bits 15:0 of that word and an odd index uses bits 31:16.
- R8: In the selected 16-bit entry, bits 4:0 are red, 9:5 green and 14:10 blue. `lut_rgb` is {red,3'b0, green,3'b0, blue,3'b0}, with red in bits 23:16 and blue in bits 7:0. Entry bit 15 has no effect.
- R9: `lut_rgb` reflects the index presented in the previous cycle. A write completed in the cycle before a lookup is visible to that lookup.
- R10: Both ends of the window are decoded exactly. 0x200 and 0x3FC address words 0 and 127, and 0x1FC and 0x400 fall outside the window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Host access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| lut_idx | input | 8 | Pixel color index |
| lut_rgb | output | 24 | Expanded color, red high |

## Verification
Random full-word and partial-lane writes over the whole window are mixed with stray writes outside it. This separates correct lane gating from whole-word overwrite, and separates window decode from address aliasing. Lookups at even and odd indices, with entries whose intensity bits and component fields are set to distinct values, show whether the right half is chosen and whether red and blue are swapped or the flag leaks in. Directed accesses at 0x1FC, 0x200, 0x3FC and 0x400 catch off-by-one decode. A lookup issued in the cycle right after a write confirms that the new color is visible there.

// File: rtl/clut_pkg.sv
package clut_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic [7:0] red;
        logic [7:0] green;
        logic [7:0] blue;
    } rgb_t;
endpackage

// File: rtl/clut_win_decode.sv
module clut_win_decode #(
    parameter int ADDR_W    = 12,
    parameter int WIN_BASE  = 'h200,
    parameter int NUM_WORDS = 128,
    localparam int IDX_W    = $clog2(NUM_WORDS),
    localparam int WIN_END  = WIN_BASE + NUM_WORDS * 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  word_idx
);
    logic [ADDR_W-1:0] off;
    logic              unused_off_bits;

    always_comb begin
        hit      = (int'(addr) >= WIN_BASE) && (int'(addr) < WIN_END);
        off      = addr - ADDR_W'(WIN_BASE);
        word_idx = off[IDX_W+1:2];
    end

    assign unused_off_bits = ^{off[1:0], off[ADDR_W-1:IDX_W+2]};
endmodule

// File: rtl/clut_word_store.sv
module clut_word_store #(
    parameter int NUM_WORDS = 128,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(NUM_WORDS),
    localparam int BE_W     = DATA_W / clut_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BE_W-1:0]   wr_be,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rda_idx,
    output logic [DATA_W-1:0] rda_word,
    input  logic [IDX_W-1:0]  rdb_idx,
    output logic [DATA_W-1:0] rdb_word
);
    typedef struct packed {
        logic [NUM_WORDS-1:0][DATA_W-1:0] mem;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int b = 0; b < BE_W; b++) begin
                if (wr_be[b]) begin
                    st_d.mem[wr_idx][b*clut_pkg::BYTE_W +: clut_pkg::BYTE_W] =
                        wr_data[b*clut_pkg::BYTE_W +: clut_pkg::BYTE_W];
                end
            end
        end
        rda_word = st_q.mem[rda_idx];
        rdb_word = st_q.mem[rdb_idx];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/clut_expand.sv
module clut_expand #(
    parameter int DATA_W  = 32,
    parameter int COMP_W  = 5,
    parameter int OUT_W   = 8,
    localparam int HALF_W = DATA_W / 2,
    localparam int PAD_W  = OUT_W - COMP_W
) (
    input  logic [DATA_W-1:0] word,
    input  logic              sel_hi,
    output logic [3*OUT_W-1:0] rgb
);
    logic [HALF_W-1:0] entry;
    logic              unused_intensity;

    assign entry = sel_hi ? word[DATA_W-1:HALF_W] : word[HALF_W-1:0];
    assign unused_intensity = ^entry[HALF_W-1:3*COMP_W];

    // component 0 = red (placed highest), 1 = green, 2 = blue
    for (genvar c = 0; c < 3; c++) begin : g_comp
        assign rgb[(2-c)*OUT_W +: OUT_W] = {entry[c*COMP_W +: COMP_W], {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/clut_palette.sv
module clut_palette #(
    parameter int ADDR_W    = 12,
    parameter int DATA_W    = 32,
    parameter int NUM_WORDS = 128,
    parameter int WIN_BASE  = 'h200,
    parameter int COMP_W    = 5,
    localparam int IDX_W    = $clog2(NUM_WORDS),
    localparam int LUT_W    = IDX_W + 1,
    localparam int BE_W     = DATA_W / clut_pkg::BYTE_W,
    localparam int RGB_W    = $bits(clut_pkg::rgb_t)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [LUT_W-1:0]  lut_idx,
    output logic [RGB_W-1:0]  lut_rgb
);
    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        clut_pkg::rgb_t    rgb;
    } out_t;

    out_t              out_d, out_q;
    logic              win_hit;
    logic [IDX_W-1:0]  win_idx;
    logic [DATA_W-1:0] bus_word;
    logic [DATA_W-1:0] lut_word;
    logic [RGB_W-1:0]  lut_color;

    clut_win_decode #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .NUM_WORDS(NUM_WORDS)
    ) u_dec (
        .addr(bus_addr), .hit(win_hit), .word_idx(win_idx)
    );

    clut_word_store #(
        .NUM_WORDS(NUM_WORDS), .DATA_W(DATA_W)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(bus_sel && bus_wr && win_hit),
        .wr_idx(win_idx), .wr_be(bus_be), .wr_data(bus_wdata),
        .rda_idx(win_idx), .rda_word(bus_word),
        .rdb_idx(lut_idx[LUT_W-1:1]), .rdb_word(lut_word)
    );

    clut_expand #(
        .DATA_W(DATA_W), .COMP_W(COMP_W), .OUT_W(RGB_W / 3)
    ) u_exp (
        .word(lut_word), .sel_hi(lut_idx[0]), .rgb(lut_color)
    );

    always_comb begin
        out_d = out_q;
        if (bus_sel && !bus_wr) begin
            out_d.rdata = win_hit ? bus_word : '0;
        end
        out_d.rgb = clut_pkg::rgb_t'(lut_color);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign bus_rdata = out_q.rdata;
    assign lut_rgb   = out_q.rgb;
endmodule

// File: rtl/clut_palette_chk.sv
module clut_palette_chk #(
    parameter int ADDR_W   = 12,
    parameter int DATA_W   = 32,
    parameter int WIN_LO   = 'h200,
    parameter int WIN_HI   = 'h400,
    parameter int LUT_W    = 8,
    parameter int RGB_W    = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W/8-1:0] bus_be,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [LUT_W-1:0]  lut_idx,
    input logic [RGB_W-1:0]  lut_rgb
);
    logic in_win;
    assign in_win = (int'(bus_addr) >= WIN_LO) && (int'(bus_addr) < WIN_HI);

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (bus_rdata == '0 && lut_rgb == '0));

    // R6
    outside_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && !in_win) |=> (bus_rdata == '0));

    // R5
    write_read_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && in_win && bus_be == '1)
        ##1 (bus_sel && !bus_wr && bus_addr[ADDR_W-1:2] == $past(bus_addr[ADDR_W-1:2]))
        |=> (bus_rdata == $past(bus_wdata, 2)));

    // R8
    pad_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lut_rgb[2:0] == 3'b0 && lut_rgb[10:8] == 3'b0 && lut_rgb[18:16] == 3'b0));

    // R9
    lookup_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(lut_idx) && !$past(bus_sel && bus_wr)) |=> $stable(lut_rgb));

    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && !bus_wr) |=> $stable(bus_rdata));
endmodule

bind clut_palette clut_palette_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_LO(WIN_BASE),
    .WIN_HI(WIN_BASE + NUM_WORDS * 4), .LUT_W(LUT_W), .RGB_W(RGB_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .lut_idx(lut_idx), .lut_rgb(lut_rgb)
);

// File: tb/sim_clut_palette.sv
module sim_clut_palette;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  lut_idx = '0;
    logic [23:0] lut_rgb;

    int compared = 0;
    int mismatched = 0;
    logic [31:0] model [128];

    always #10 clk = ~clk;

    clut_palette u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .lut_idx(lut_idx), .lut_rgb(lut_rgb)
    );

    function automatic bit in_win(input logic [11:0] a);
        return (a >= 12'h200) && (a < 12'h400);
    endfunction

    function automatic logic [23:0] exp_rgb(input logic [7:0] idx);
        logic [31:0] w;
        logic [15:0] e;
        w = model[idx[7:1]];
        e = idx[0] ? w[31:16] : w[15:0];
        return {e[4:0], 3'b0, e[9:5], 3'b0, e[14:10], 3'b0};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        if (in_win(a)) begin
            for (int b = 0; b < 4; b++)
                if (be[b]) model[a[8:2]][b*8 +: 8] = d[b*8 +: 8];
        end
    endtask

    task automatic do_read(input logic [11:0] a, input string tag);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        check(tag, bus_rdata, in_win(a) ? model[a[8:2]] : 32'h0);
    endtask

    task automatic do_lookup(input logic [7:0] idx, input string tag);
        @(negedge clk);
        lut_idx = idx;
        @(negedge clk);
        check(tag, {8'h0, lut_rgb}, {8'h0, exp_rgb(idx)});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 128; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        // R1: outputs zero in reset
        check("R1 rdata in reset", bus_rdata, 32'h0);
        check("R1 rgb in reset", {8'h0, lut_rgb}, 32'h0);
        rst_n = 1'b1;
        do_read(12'h200, "R1 word0 after reset");
        do_read(12'h3FC, "R1 word127 after reset");
        do_lookup(8'hFF, "R1 lookup after reset");

        // R10 / R2: window ends, low address bits ignored
        do_write(12'h200, 4'hF, 32'hA5A5_1234);
        do_write(12'h3FF, 4'hF, 32'h8001_7FFF);
        do_read(12'h202, "R2 R10 low bound word0");
        do_read(12'h3FC, "R10 high bound word127");
        do_read(12'h1FC, "R10 below window reads zero");
        do_read(12'h400, "R6 R10 above window reads zero");

        // R4: stray writes do not alias into the window
        do_write(12'h000, 4'hF, 32'hDEAD_BEEF);
        do_write(12'h1FC, 4'hF, 32'hDEAD_BEEF);
        do_write(12'h400, 4'hF, 32'hDEAD_BEEF);
        do_write(12'h5FC, 4'hF, 32'hDEAD_BEEF);
        do_read(12'h200, "R4 word0 untouched");
        do_read(12'h3FC, "R4 word127 untouched");

        // R3: partial lanes
        do_write(12'h240, 4'hF, 32'h1122_3344);
        do_write(12'h240, 4'b0101, 32'hAABB_CCDD);
        do_read(12'h240, "R3 lanes 0 and 2");
        do_write(12'h240, 4'b1000, 32'hEE00_0000);
        do_read(12'h240, "R3 lane 3 only");

        // R7 / R8: halves, component order, intensity ignored
        do_write(12'h300, 4'hF, {1'b1, 5'h03, 5'h0A, 5'h11, 1'b1, 5'h1F, 5'h00, 5'h15});
        do_lookup(8'h80, "R7 R8 even entry");
        do_lookup(8'h81, "R7 R8 odd entry");
        do_read(12'h300, "R5 raw word keeps intensity bits");
        do_write(12'h304, 4'hF, 32'h8000_8000);
        do_lookup(8'h82, "R8 intensity alone gives black");
        do_lookup(8'h83, "R8 intensity alone gives black odd");

        // R9: lookup in cycle right after write sees new color
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h2A0; bus_be = 4'hF; bus_wdata = 32'h7C1F_03E0;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; lut_idx = 8'h51;
        model[8'h28] = 32'h7C1F_03E0;
        @(negedge clk);
        check("R9 write then next-cycle lookup", {8'h0, lut_rgb}, {8'h0, exp_rgb(8'h51)});

        // R5: rdata holds between reads
        do_read(12'h2A0, "R5 read value");
        repeat (3) @(negedge clk);
        check("R5 rdata held", bus_rdata, model[8'h28]);

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [11:0] a;
            int kind;
            kind = $urandom_range(0, 9);
            a = 12'h200 + 12'($urandom_range(0, 511));
            if (kind < 4)       do_write(a, 4'($urandom_range(1, 15)), $urandom);
            else if (kind == 4) do_write(12'($urandom_range(0, 4095)), 4'hF, $urandom);
            else if (kind < 7)  do_read(a, "R2 R3 random read");
            else if (kind == 7) do_read(12'($urandom_range(0, 4095)), "R4 R6 random read");
            else                do_lookup(8'($urandom_range(0, 255)), "R7 R8 random lookup");
        end
        for (int i = 0; i < 128; i++) do_read(12'h200 + 12'(i * 4), "R2 R4 final sweep");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule